// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches one 32-pin general-purpose input port and turns pin activity into a single interrupt line. Each pin input is brought into the clock domain through two flops. The synchronized value is then compared with its value one cycle earlier to find events. By default a pin raises an event on any change. Software can select an alternate trigger per pin instead: a rising edge, a falling edge, a high level or a low level. Events are latched in a status register that clears when it is read. The status is masked by a per-pin enable register, and the port interrupt output is raised while any enabled status bit is set.

All configuration uses paired write-one registers, one that sets bits and one that clears them. Bits written as zero leave the state unchanged, so several drivers can share the port without read-modify-write races. A per-pin security-level register sits behind a write-protect register. The write-protect register only accepts writes that carry a fixed key in the upper bits.

Software reaches the block through a simple 32-bit register bus. A write takes effect on the clock edge at which `wr_en` is high. Read data is combinational from `addr` while `rd_en` is high, and a status read clears the status on that same edge.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the mask, alternate-mode, level-select, polarity, write-protect and security registers and the status all read zero, and `irq_o` is low.
- R2: With alternate mode off for a pin, a rising or falling change on the pin sets its status bit. The bit can be read three clock edges after the pin changes (two synchronizer flops plus the status latch).
- R3: Reading STATUS (0x0C) returns the latched events and clears them on the same edge. An event that arrives on the edge of a clearing read stays set afterwards.
- R4: Writing a one to bit n of MASK_ON (0x00) enables pin n, and writing a one to bit n of MASK_OFF (0x04) disables it. Zero bits have no effect. MASK (0x08) reads back the current mask.
- R5: `irq_o` is high exactly when some pin has both its status bit and its mask bit set.
- R6: Writing ones to ALT_ON (0x10) or ALT_OFF (0x14) turns alternate mode on or off for the selected pins. ALT (0x18) reads back the current mode.
- R7: In alternate edge mode, a pin with its polarity bit set raises an event only on a rising edge. A pin with its polarity bit clear raises an event only on a falling edge.
- R8: In alternate level mode, the status bit is set again on every cycle that the active level is present. A read therefore clears it only after the level has gone.
- R9: Writing ones to SEL_LEVEL (0x1C) or SEL_EDGE (0x20) sets or clears the level-select bits, and LEVEL (0x24) reads them back. Writing ones to POL_HIGH (0x28) or POL_LOW (0x2C) sets or clears the polarity bits, and POL (0x30) reads them back.
- R10: A write to WPROT (0x34) changes the protect-enable bit (bit 0) only when bits 31:8 equal 0xC0DE5A. A write with any other key has no effect. Reading WPROT returns the enable bit in bit 0.
- R11: SECURE (0x38) is readable and writable. A clear bit marks that pin's interrupt as secure and a set bit marks it non-secure. While protection is enabled, writes to SECURE are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| pins_i | input | 32 | Asynchronous pin inputs |
| irq_o | output | 1 | Combined port interrupt |

## Verification
The assertions assume that a single register access occurs per cycle: `wr_en` and `rd_en` are never high together, and each access targets one address. The write-data checks also rely on the bus holding `wdata` stable for the cycle of the write. The bench drives every access from a task that raises exactly one strobe at the falling clock edge and drops it just after the next rising edge. It changes pins only at falling edges, so the synchronizer latency is exact and every status value can be predicted cycle by cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_MASK_ON   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_MASK_OFF  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MASK      = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_STATUS    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_ALT_ON    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_ALT_OFF   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ALT       = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_SEL_LEVEL = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_SEL_EDGE  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_LEVEL     = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_POL_HIGH  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_POL_LOW   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_POL       = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_WPROT     = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_SECURE    = 8'h38;

  localparam int KEY_W  = 24;
  localparam int KEY_LO = DATA_W - KEY_W;
  localparam logic [KEY_W-1:0] WP_KEY = 24'hC0DE5A;

  // Trigger decision for one pin from its configuration and its
  // current and previous synchronized values.
  function automatic logic pin_event(input logic alt, input logic lvl,
                                     input logic pol, input logic cur,
                                     input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (!alt)
      return rise | fall;
    else if (lvl)
      return pol ? cur : ~cur;
    else
      return pol ? rise : fall;
  endfunction

  // Write-one-to-set / write-one-to-clear update
  function automatic logic [DATA_W-1:0] w1_update(input logic [DATA_W-1:0] cur,
                                                  input logic [DATA_W-1:0] set_b,
                                                  input logic [DATA_W-1:0] clr_b);
    return (cur | set_b) & ~clr_b;
  endfunction

  function automatic logic key_ok(input logic [DATA_W-1:0] wd);
    return wd[DATA_W-1:KEY_LO] == WP_KEY;
  endfunction

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      cur_o  <= '0;
      prev_o <= '0;
    end else begin
      stage1 <= pins_i;
      cur_o  <= stage1;
      prev_o <= cur_o;
    end
  end

endmodule

// File: rtl/pic_detect.sv
module pic_detect
  import pic_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] alt_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] evt_o
);

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign evt_o[g] = pin_event(alt_i[g], lvl_i[g], pol_i[g], cur_i[g], prev_i[g]);
  end

endmodule

// File: rtl/pic_status.sv
module pic_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clear_i,
  output logic [W-1:0] status_o
);

  logic [W-1:0] kept;

  // A clearing read drops old bits; new events are ORed in afterwards
  assign kept = clear_i ? '0 : status_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= kept | evt_i;
  end

endmodule

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [W-1:0]      status_i,
  output logic              rd_status_o,
  output logic [W-1:0]      mask_o,
  output logic [W-1:0]      alt_o,
  output logic [W-1:0]      lvl_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      sec_o,
  output logic              wp_en_o
);

  logic [DATA_W-1:0] wd_ext;
  logic [DATA_W-1:0] mask_set, mask_clr, alt_set, alt_clr;
  logic [DATA_W-1:0] lvl_set, lvl_clr, pol_set, pol_clr;
  logic [DATA_W-1:0] mask_nx, alt_nx, lvl_nx, pol_nx;
  logic [DATA_W-1:0] mask_ext, alt_ext, lvl_ext, pol_ext;

  always_comb begin
    wd_ext = '0;
    wd_ext[W-1:0] = wdata[W-1:0];
  end

  assign mask_set = (wr_en && addr == OFF_MASK_ON)   ? wd_ext : '0;
  assign mask_clr = (wr_en && addr == OFF_MASK_OFF)  ? wd_ext : '0;
  assign alt_set  = (wr_en && addr == OFF_ALT_ON)    ? wd_ext : '0;
  assign alt_clr  = (wr_en && addr == OFF_ALT_OFF)   ? wd_ext : '0;
  assign lvl_set  = (wr_en && addr == OFF_SEL_LEVEL) ? wd_ext : '0;
  assign lvl_clr  = (wr_en && addr == OFF_SEL_EDGE)  ? wd_ext : '0;
  assign pol_set  = (wr_en && addr == OFF_POL_HIGH)  ? wd_ext : '0;
  assign pol_clr  = (wr_en && addr == OFF_POL_LOW)   ? wd_ext : '0;

  always_comb begin
    mask_ext = '0; mask_ext[W-1:0] = mask_o;
    alt_ext  = '0; alt_ext[W-1:0]  = alt_o;
    lvl_ext  = '0; lvl_ext[W-1:0]  = lvl_o;
    pol_ext  = '0; pol_ext[W-1:0]  = pol_o;
  end

  assign mask_nx = w1_update(mask_ext, mask_set, mask_clr);
  assign alt_nx  = w1_update(alt_ext,  alt_set,  alt_clr);
  assign lvl_nx  = w1_update(lvl_ext,  lvl_set,  lvl_clr);
  assign pol_nx  = w1_update(pol_ext,  pol_set,  pol_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      alt_o  <= '0;
      lvl_o  <= '0;
      pol_o  <= '0;
    end else begin
      mask_o <= mask_nx[W-1:0];
      alt_o  <= alt_nx[W-1:0];
      lvl_o  <= lvl_nx[W-1:0];
      pol_o  <= pol_nx[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_en_o <= 1'b0;
      sec_o   <= '0;
    end else if (wr_en) begin
      if (addr == OFF_WPROT && key_ok(wdata)) wp_en_o <= wdata[0];
      if (addr == OFF_SECURE && !wp_en_o)     sec_o   <= wdata[W-1:0];
    end
  end

  assign rd_status_o = rd_en && (addr == OFF_STATUS);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_MASK:   rdata[W-1:0] = mask_o;
        OFF_STATUS: rdata[W-1:0] = status_i;
        OFF_ALT:    rdata[W-1:0] = alt_o;
        OFF_LEVEL:  rdata[W-1:0] = lvl_o;
        OFF_POL:    rdata[W-1:0] = pol_o;
        OFF_WPROT:  rdata[0]     = wp_en_o;
        OFF_SECURE: rdata[W-1:0] = sec_o;
        default:    rdata        = '0;
      endcase
    end
  end

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pic_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [W-1:0]      pins_i,
  output logic              irq_o
);

  logic [W-1:0] cur, prev, evt, status;
  logic [W-1:0] mask, alt, lvl, pol, sec;
  logic         wp_en, rd_status;

  pic_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .cur_o(cur), .prev_o(prev)
  );

  pic_detect #(.W(W)) u_detect (
    .cur_i(cur), .prev_i(prev), .alt_i(alt), .lvl_i(lvl), .pol_i(pol),
    .evt_o(evt)
  );

  pic_status #(.W(W)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clear_i(rd_status),
    .status_o(status)
  );

  pic_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .status_i(status), .rd_status_o(rd_status),
    .mask_o(mask), .alt_o(alt), .lvl_o(lvl), .pol_o(pol), .sec_o(sec),
    .wp_en_o(wp_en)
  );

  assign irq_o = |(status & mask);

endmodule

// File: rtl/pic_chk.sv
module pic_chk
  import pic_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_o,
  input logic [W-1:0]      mask,
  input logic [W-1:0]      status,
  input logic [W-1:0]      evt,
  input logic [W-1:0]      sec,
  input logic              wp_en
);

  // R3
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_STATUS && evt == '0) |=> status == '0);

  // R3
  event_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

  // R4
  mask_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MASK_ON) |=>
      ((mask & $past(wdata[W-1:0])) == $past(wdata[W-1:0])));

  // R4
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_MASK_OFF) |=> ((mask & $past(wdata[W-1:0])) == '0));

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq_o);

  // R10
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_WPROT && wdata[DATA_W-1:KEY_LO] != WP_KEY) |=> $stable(wp_en));

  // R11
  sec_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_en && wr_en && addr == OFF_SECURE) |=> $stable(sec));

endmodule

bind pin_irq_ctrl pic_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .irq_o(irq_o), .mask(mask), .status(status), .evt(evt),
  .sec(sec), .wp_en(wp_en)
);

// File: tb/test_pin_irq_ctrl.sv
module test_pin_irq_ctrl;
  import pic_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [31:0]       pins = '0;
  logic              irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
    bit          is_irq;
  } item_t;

  item_t sb_q[$];
  event  smp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl #(.W(32)) i_pin_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pins_i(pins), .irq_o(irq_o)
  );

  // Monitor: pops the expected item and compares with the sampled output
  initial begin
    forever begin
      @(smp);
      if (sb_q.size() != 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp = e; it.tag = tag; it.is_irq = 1'b0;
    sb_q.push_back(it);
    #(CLK_PERIOD/4) ->smp;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = {31'b0, e}; it.tag = tag; it.is_irq = 1'b1;
    sb_q.push_back(it);
    #(CLK_PERIOD/4) ->smp;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd_chk(OFF_MASK,   32'h0, "R1 mask");
    rd_chk(OFF_STATUS, 32'h0, "R1 status");
    rd_chk(OFF_ALT,    32'h0, "R1 alt");
    rd_chk(OFF_LEVEL,  32'h0, "R1 level");
    rd_chk(OFF_POL,    32'h0, "R1 pol");
    rd_chk(OFF_WPROT,  32'h0, "R1 wprot");
    rd_chk(OFF_SECURE, 32'h0, "R1 secure");
    irq_chk(1'b0, "R1 irq");

    // R2 any change in default mode, R3 clear on read
    set_pins(32'h8); settle();
    rd_chk(OFF_STATUS, 32'h8, "R2 rise pin3");
    rd_chk(OFF_STATUS, 32'h0, "R3 cleared");
    set_pins(32'h0); settle();
    rd_chk(OFF_STATUS, 32'h8, "R2 fall pin3");
    rd_chk(OFF_STATUS, 32'h0, "R3 cleared again");

    // R3 event on the edge of a clearing read is kept
    set_pins(32'h20);
    @(posedge clk); @(posedge clk);
    rd_chk(OFF_STATUS, 32'h0, "R3 read during event");
    rd_chk(OFF_STATUS, 32'h20, "R3 event kept");
    set_pins(32'h0); settle();
    rd_chk(OFF_STATUS, 32'h20, "R3 drain");

    // R4 mask write-one set/clear
    wr(OFF_MASK_ON, 32'hF0);
    rd_chk(OFF_MASK, 32'hF0, "R4 set");
    wr(OFF_MASK_ON, 32'h0);
    rd_chk(OFF_MASK, 32'hF0, "R4 zero write no effect");
    wr(OFF_MASK_OFF, 32'h30);
    rd_chk(OFF_MASK, 32'hC0, "R4 clear");

    // R5 combined interrupt
    set_pins(32'h80); settle();
    irq_chk(1'b1, "R5 masked-in event");
    rd_chk(OFF_STATUS, 32'h80, "R5 status");
    irq_chk(1'b0, "R5 after clear");
    set_pins(32'h81); settle();
    irq_chk(1'b0, "R5 masked-out event");
    rd_chk(OFF_STATUS, 32'h1, "R5 masked status");
    set_pins(32'h0); settle();
    irq_chk(1'b1, "R5 pin7 fall");
    rd_chk(OFF_STATUS, 32'h81, "R5 both fall");

    // R6 / R9 alternate edge configuration
    wr(OFF_POL_HIGH, 32'h2);
    wr(OFF_SEL_EDGE, 32'h2);
    wr(OFF_ALT_ON, 32'h2);
    rd_chk(OFF_ALT,   32'h2, "R6 alt on");
    rd_chk(OFF_POL,   32'h2, "R9 pol high");
    rd_chk(OFF_LEVEL, 32'h0, "R9 edge select");
    // R7 rising only
    set_pins(32'h2); settle();
    rd_chk(OFF_STATUS, 32'h2, "R7 rising event");
    set_pins(32'h0); settle();
    rd_chk(OFF_STATUS, 32'h0, "R7 no fall event");
    wr(OFF_POL_LOW, 32'h2);
    rd_chk(OFF_POL, 32'h0, "R9 pol low");
    set_pins(32'h2); settle();
    rd_chk(OFF_STATUS, 32'h0, "R7 no rise event");
    set_pins(32'h0); settle();
    rd_chk(OFF_STATUS, 32'h2, "R7 falling event");

    // R8 level high mode on pin2
    wr(OFF_SEL_LEVEL, 32'h4);
    wr(OFF_POL_HIGH, 32'h4);
    wr(OFF_ALT_ON, 32'h4);
    rd_chk(OFF_LEVEL, 32'h4, "R9 level select");
    rd_chk(OFF_STATUS, 32'h0, "R8 inactive level");
    set_pins(32'h4); settle();
    rd_chk(OFF_STATUS, 32'h4, "R8 level seen");
    rd_chk(OFF_STATUS, 32'h4, "R8 level persists");
    set_pins(32'h0); settle();
    rd_chk(OFF_STATUS, 32'h4, "R8 last latched");
    rd_chk(OFF_STATUS, 32'h0, "R8 gone after level");
    wr(OFF_ALT_OFF, 32'h6);
    rd_chk(OFF_ALT, 32'h0, "R6 alt off");

    // R10 / R11 write protection and security level
    wr(OFF_WPROT, {24'h123456, 8'h01});
    rd_chk(OFF_WPROT, 32'h0, "R10 wrong key ignored");
    wr(OFF_SECURE, 32'hFFFF0000);
    rd_chk(OFF_SECURE, 32'hFFFF0000, "R11 unprotected write");
    wr(OFF_WPROT, {WP_KEY, 8'h01});
    rd_chk(OFF_WPROT, 32'h1, "R10 protect on");
    wr(OFF_SECURE, 32'h1);
    rd_chk(OFF_SECURE, 32'hFFFF0000, "R11 protected write ignored");
    wr(OFF_WPROT, {24'h000000, 8'h00});
    rd_chk(OFF_WPROT, 32'h1, "R10 wrong key keeps protect");
    wr(OFF_WPROT, {WP_KEY, 8'h00});
    rd_chk(OFF_WPROT, 32'h0, "R10 protect off");
    wr(OFF_SECURE, 32'h55);
    rd_chk(OFF_SECURE, 32'h55, "R11 writable again");

    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end

endmodule